// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits between instruction decode and two integer issue lanes of unequal capability. Every cycle it looks at the two oldest decoded instructions and decides whether both can leave together. The older one ("A") always goes to the full lane. The younger one ("B") either joins it in the restricted lane or is held back, so that it becomes the older instruction in the following cycle. Issue therefore stays in program order.

Each instruction arrives as a descriptor with these fields:
- a valid flag;
- a three-bit class code;
- a destination register index and a flag that says whether the destination is written;
- two source register indices.

The restricted lane has no shifter. It takes only plain integer operations, or a floating-point register exchange that follows a simple floating-point operation. The block also refuses to pair when B reads or overwrites the register that A writes.

The decision is registered. The three outputs describe the pair that was presented at the previous rising clock edge.

Top module: `pair_issue`

## Requirements
- R1: The outputs `issue_u`, `issue_v` and `hold_b` are registered. Each one reflects the inputs sampled at the previous rising edge of `clk`. While `rst_n` is low, all three are 0.
- R2: `issue_u` equals `a_valid`. The older instruction always issues to the full lane, whatever its class.
- R3: A B instruction of class 1 (shift) never issues in the restricted lane.
- R4: Class 2 (complex integer), class 5 (complex floating point) and classes 6 and 7 never pair, whether they are A or B.
- R5: A B instruction of class 4 (floating-point exchange) pairs only when A is class 3 (simple floating point). An exchange in the A position never pairs.
- R6: A B instruction of class 0 (simple integer) pairs only when A is class 0 or class 1.
- R7: Pairing is refused when `a_wr` is 1 and either `b_src0` or `b_src1` equals `a_dst`.
- R8: Pairing is refused when both `a_wr` and `b_wr` are 1 and `a_dst` equals `b_dst`.
- R9: If either valid flag is low, `issue_v` is 0. `hold_b` is 1 exactly when `b_valid` was 1 and the pair was refused. `issue_v` and `hold_b` are never 1 together.
- R10: When `a_wr` is 0, a B source or destination that matches `a_dst` does not block pairing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | Older instruction present |
| a_class | input | 3 | Older instruction class code |
| a_dst | input | REG_W | Older destination register |
| a_wr | input | 1 | Older instruction writes `a_dst` |
| a_src0 | input | REG_W | Older first source register |
| a_src1 | input | REG_W | Older second source register |
| b_valid | input | 1 | Younger instruction present |
| b_class | input | 3 | Younger instruction class code |
| b_dst | input | REG_W | Younger destination register |
| b_wr | input | 1 | Younger instruction writes `b_dst` |
| b_src0 | input | REG_W | Younger first source register |
| b_src1 | input | REG_W | Younger second source register |
| issue_u | output | 1 | Older instruction issues to the full lane |
| issue_v | output | 1 | Younger instruction issues to the restricted lane |
| hold_b | output | 1 | Younger instruction is held for the next cycle |

## Verification
The only state is the three-bit decision register, so any fault shows up one edge after the offending pair is presented. It appears either as a lost or extra restricted-lane issue, or as a held instruction that should have issued. A stale or wrongly reset register shows up in the first cycle after reset is released. A fault in the dependency compare or the class table appears only on the particular pairs that reach that term. For this reason the stimulus walks each class combination and each matching-index case before it moves to random pairs.

// File: rtl/pair_issue.sv
module pair_issue #(
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_valid,
  input  logic [2:0]       a_class,
  input  logic [REG_W-1:0] a_dst,
  input  logic             a_wr,
  input  logic [REG_W-1:0] a_src0,
  input  logic [REG_W-1:0] a_src1,
  input  logic             b_valid,
  input  logic [2:0]       b_class,
  input  logic [REG_W-1:0] b_dst,
  input  logic             b_wr,
  input  logic [REG_W-1:0] b_src0,
  input  logic [REG_W-1:0] b_src1,
  output logic             issue_u,
  output logic             issue_v,
  output logic             hold_b
);
  localparam logic [2:0] CL_INT = 3'd0;
  localparam logic [2:0] CL_SHF = 3'd1;
  localparam logic [2:0] CL_FPS = 3'd3;
  localparam logic [2:0] CL_XCH = 3'd4;

  logic a_unused;
  assign a_unused = ^{a_src0, a_src1};

  logic int_ok, xch_ok, raw, waw, pair;
  assign int_ok = (b_class == CL_INT) && (a_class == CL_INT || a_class == CL_SHF);
  assign xch_ok = (b_class == CL_XCH) && (a_class == CL_FPS);
  assign raw    = a_wr && (b_src0 == a_dst || b_src1 == a_dst);
  assign waw    = a_wr && b_wr && (a_dst == b_dst);
  assign pair   = a_valid && b_valid && (int_ok || xch_ok) && !raw && !waw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_u <= 1'b0;
      issue_v <= 1'b0;
      hold_b  <= 1'b0;
    end else begin
      issue_u <= a_valid;
      issue_v <= pair;
      hold_b  <= b_valid && !pair;
    end
  end

  a_r9_v_needs_u: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> issue_u);
  a_r9_v_or_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_v && hold_b));
  a_r3_no_shift_v: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> $past(b_class) != CL_SHF);
  a_r5_xch_after_fp: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_v && $past(b_class) == CL_XCH) |-> $past(a_class) == CL_FPS);
  a_r4_v_class: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> ($past(b_class) == CL_INT || $past(b_class) == CL_XCH));
  a_r7_no_raw: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> !($past(a_wr) && ($past(b_src0) == $past(a_dst) || $past(b_src1) == $past(a_dst))));
  a_r8_no_waw: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> !($past(a_wr) && $past(b_wr) && $past(b_dst) == $past(a_dst)));
endmodule

// File: tb/pair_issue_tb.sv
`timescale 1ns/1ps
module pair_issue_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       a_v, a_w, b_v, b_w;
  logic [2:0] a_c, b_c, a_d, a_s0, a_s1, b_d, b_s0, b_s1;
  logic       issue_u, issue_v, hold_b;
  int checks = 0;
  int fails = 0;

  pair_issue #(.REG_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_v), .a_class(a_c), .a_dst(a_d), .a_wr(a_w), .a_src0(a_s0), .a_src1(a_s1),
    .b_valid(b_v), .b_class(b_c), .b_dst(b_d), .b_wr(b_w), .b_src0(b_s0), .b_src1(b_s1),
    .issue_u(issue_u), .issue_v(issue_v), .hold_b(hold_b)
  );

  function automatic bit model_pair();
    if (!a_v || !b_v) return 1'b0;
    if (a_w && (b_s0 == a_d || b_s1 == a_d)) return 1'b0;
    if (a_w && b_w && b_d == a_d) return 1'b0;
    case (b_c)
      3'd0:    return (a_c == 3'd0 || a_c == 3'd1);
      3'd4:    return (a_c == 3'd3);
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic set_in(input logic av, input logic [2:0] ac, input logic [2:0] ad, input logic aw,
                        input logic bv, input logic [2:0] bc, input logic [2:0] bd, input logic bw,
                        input logic [2:0] bs0, input logic [2:0] bs1);
    a_v = av; a_c = ac; a_d = ad; a_w = aw; a_s0 = 3'd6; a_s1 = 3'd7;
    b_v = bv; b_c = bc; b_d = bd; b_w = bw; b_s0 = bs0; b_s1 = bs1;
  endtask

  task automatic step(input string tag);
    logic eu, ev, eh;
    eu = a_v;
    ev = model_pair();
    eh = b_v && !ev;
    @(negedge clk);
    check(tag, "issue_u", issue_u, eu);
    check(tag, "issue_v", issue_v, ev);
    check(tag, "hold_b", hold_b, eh);
  endtask

  initial begin
    set_in(1, 0, 1, 1, 1, 0, 2, 1, 3, 4);
    repeat (3) @(negedge clk);
    check("R1", "issue_u", issue_u, 1'b0);
    check("R1", "issue_v", issue_v, 1'b0);
    check("R1", "hold_b", hold_b, 1'b0);
    rst_n = 1'b1;
    step("R1");
    set_in(1, 1, 1, 1, 1, 0, 2, 1, 3, 4); step("R6");
    set_in(1, 0, 1, 1, 1, 1, 2, 1, 3, 4); step("R3");
    set_in(1, 1, 1, 1, 1, 1, 2, 1, 3, 4); step("R3");
    set_in(1, 2, 1, 1, 1, 0, 2, 1, 3, 4); step("R4");
    set_in(1, 0, 1, 1, 1, 2, 2, 1, 3, 4); step("R4");
    set_in(1, 3, 1, 1, 1, 5, 2, 1, 3, 4); step("R4");
    set_in(1, 3, 1, 1, 1, 4, 2, 1, 3, 4); step("R5");
    set_in(1, 4, 1, 1, 1, 3, 2, 1, 3, 4); step("R5");
    set_in(1, 0, 1, 1, 1, 4, 2, 1, 3, 4); step("R5");
    set_in(1, 3, 1, 1, 1, 0, 2, 1, 3, 4); step("R6");
    set_in(1, 0, 5, 1, 1, 0, 2, 1, 5, 4); step("R7");
    set_in(1, 0, 5, 1, 1, 0, 2, 1, 3, 5); step("R7");
    set_in(1, 0, 5, 1, 1, 0, 5, 1, 3, 4); step("R8");
    set_in(1, 0, 5, 1, 1, 0, 5, 0, 3, 4); step("R8");
    set_in(1, 0, 5, 0, 1, 0, 5, 1, 5, 5); step("R10");
    set_in(0, 0, 1, 1, 1, 0, 2, 1, 3, 4); step("R9");
    set_in(1, 0, 1, 1, 0, 0, 2, 1, 3, 4); step("R9");
    set_in(1, 2, 1, 1, 0, 0, 2, 1, 3, 4); step("R2");
    for (int i = 0; i < 400; i++) begin
      set_in($urandom_range(0, 1), 3'($urandom), 3'($urandom), $urandom_range(0, 1),
             $urandom_range(0, 1), 3'($urandom), 3'($urandom), $urandom_range(0, 1),
             3'($urandom), 3'($urandom));
      step("R2");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule